// File: doc/BRIEF.md
# Power-Mode Supervisor State Machine

This block decides the operating mode of a bus transceiver companion device. It tracks five modes: Off, Standby, Normal, Sleep and Overtemp. It moves between them on digitized supply and temperature comparator flags, wake-up strobes from the CAN channel, the LIN channels and a local source, a system-reset request, and writes to a 2-bit mode-control field. From the current mode it drives the enables for the primary (V1) and secondary (V2) regulators, a state code for each transceiver, a timed reset pulse and a one-hot mode status.

Supply and thermal events take precedence over software requests. The order within one cycle is fixed: power-off detection, then overtemperature, then the system reset request, then wake events, then mode writes. The 2-bit control value picks the target mode and also the V2 enable. The reset pulse comes from a down-counter with two selectable terminal counts. Every new reset cause reloads the counter.

Top module: `pwr_mode_sup`

## Requirements
- R1: While `rstN` is low, and after it is released with no flag active, the mode is Off, `modeOneHot` is 5'b00001, both regulator enables are 0, every transceiver code is Off and `rstOut` is 0.
- R2: When `batOffFlag` is 1, the next mode is Off from any mode. This overrides every other input in the same cycle.
- R3: In Off with `batOnFlag` high, the block enters Standby on the next edge and starts a reset pulse. `rstOut` then stays 1 for exactly SHORT_CYC cycles if `longRstSel` was 0 at the start, or LONG_CYC cycles if it was 1.
- R4: In Standby, a mode write moves the block as follows: 01 to Sleep, 10 to Normal with V2 off, 11 to Normal with V2 on. A write of 00 leaves the mode unchanged.
- R5: In Normal, a write of 00 moves to Standby and 01 moves to Sleep. A write of 10 or 11 keeps Normal and sets V2 off or on.
- R6: A system reset request in Normal moves to Standby and starts a reset pulse, taking priority over a write in the same cycle. A request in Standby keeps Standby and starts a pulse.
- R7: In Sleep, any wake strobe (CAN, any LIN, local) moves to Standby. Mode writes and reset requests are ignored in Sleep.
- R8: In Standby, `tempHiFlag` moves to Overtemp, taking priority over a reset request and a write. Overtemp is held until `tempLoFlag` moves it to Standby. Mode writes have no effect in Off or Overtemp.
- R9: `v1En` is 1 only in Standby and Normal. `v2En` is 1 only in Normal with V2 selected.
- R10: Each transceiver has a 2-bit code at bits [2i+1:2i]: 00 Off, 01 Lowpower, 10 Active. Channel 0 is CAN and channel i>0 is LIN i. In Off and Overtemp every code is Off. In Standby and Sleep a channel is Lowpower when its `stbCtrl` bit is 1 and Off when it is 0. In Normal a channel is Lowpower when its bit is 1 and Active when it is 0.
- R11: `modeOneHot` has exactly one bit set: bit 0 Off, bit 1 Standby, bit 2 Normal, bit 3 Sleep, bit 4 Overtemp.
- R12: A new reset cause while a pulse is running reloads the counter. The pulse then lasts the full selected length from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| batOnFlag | input | 1 | Battery above power-on level |
| batOffFlag | input | 1 | Battery below power-off level |
| tempHiFlag | input | 1 | Temperature above activation level |
| tempLoFlag | input | 1 | Temperature below release level |
| wakeCan | input | 1 | CAN wake-up strobe |
| wakeLin | input | NUM_LIN | LIN wake-up strobes, one per channel |
| wakeLocal | input | 1 | Local wake-up strobe |
| sysRstReq | input | 1 | System reset request |
| modeWrEn | input | 1 | Mode-control write strobe |
| modeWrData | input | 2 | Mode-control write value |
| longRstSel | input | 1 | 1 selects the long reset pulse |
| stbCtrl | input | NUM_LIN+1 | Per-transceiver standby-control bits, bit 0 CAN |
| v1En | output | 1 | Primary regulator enable |
| v2En | output | 1 | Secondary regulator enable |
| xcvrState | output | 2*(NUM_LIN+1) | Per-transceiver state codes |
| rstOut | output | 1 | System reset pulse |
| modeOneHot | output | 5 | One-hot current mode |

## Verification
The bench builds the block with SHORT_CYC=4, LONG_CYC=12 and NUM_LIN=2. With these values, whole reset pulses of both lengths, and a restart in the middle of a pulse, fit in a few dozen cycles. Every state code of all three transceivers can be observed. Each stimulus step drives the cycle's inputs into a reference transition model that predicts mode, enables, codes and pulse level. A monitor compares those predictions with the ports one cycle later. The sequences cover every legal mode edge, the priority conflicts, and the writes that must be ignored.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    MD_OFF   = 3'd0,
    MD_STBY  = 3'd1,
    MD_NORM  = 3'd2,
    MD_SLEEP = 3'd3,
    MD_OVT   = 3'd4
  } modeT;

  typedef enum logic [1:0] {
    XS_OFF = 2'b00,
    XS_LOW = 2'b01,
    XS_ACT = 2'b10
  } xcvrT;

  localparam int NUM_MODES = 5;

  typedef struct packed {
    logic rstStart;
    logic v2Load;
    logic v2Val;
  } ctlStrobeT;

endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
#(
  parameter int NUM_LIN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               batOnFlag,
  input  logic               batOffFlag,
  input  logic               tempHiFlag,
  input  logic               tempLoFlag,
  input  logic               wakeCan,
  input  logic [NUM_LIN-1:0] wakeLin,
  input  logic               wakeLocal,
  input  logic               sysRstReq,
  input  logic               modeWrEn,
  input  logic [1:0]         modeWrData,
  output modeT               modeQ,
  output ctlStrobeT          strobe
);

  modeT modeD;
  logic anyWake;

  assign anyWake = wakeCan | (|wakeLin) | wakeLocal;

  always_comb begin
    modeD  = modeQ;
    strobe = '0;
    if (batOffFlag) begin
      modeD = MD_OFF;
    end else begin
      case (modeQ)
        MD_OFF: begin
          if (batOnFlag) begin
            modeD           = MD_STBY;
            strobe.rstStart = 1'b1;
          end
        end
        MD_STBY: begin
          if (tempHiFlag) begin
            modeD = MD_OVT;
          end else if (sysRstReq) begin
            strobe.rstStart = 1'b1;
          end else if (modeWrEn) begin
            case (modeWrData)
              2'b01: modeD = MD_SLEEP;
              2'b10, 2'b11: begin
                modeD         = MD_NORM;
                strobe.v2Load = 1'b1;
                strobe.v2Val  = modeWrData[0];
              end
              default: modeD = MD_STBY;
            endcase
          end
        end
        MD_NORM: begin
          if (sysRstReq) begin
            modeD           = MD_STBY;
            strobe.rstStart = 1'b1;
          end else if (modeWrEn) begin
            case (modeWrData)
              2'b00: modeD = MD_STBY;
              2'b01: modeD = MD_SLEEP;
              default: begin
                strobe.v2Load = 1'b1;
                strobe.v2Val  = modeWrData[0];
              end
            endcase
          end
        end
        MD_SLEEP: begin
          if (anyWake) modeD = MD_STBY;
        end
        MD_OVT: begin
          if (tempLoFlag) modeD = MD_STBY;
        end
        default: modeD = MD_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MD_OFF;
    else       modeQ <= modeD;
  end

  // R2: power-off detection wins from any mode
  a_r2_poweroff_wins: assert property (@(posedge clk) disable iff (!rstN)
    batOffFlag |=> modeQ == MD_OFF);

  // R8: overtemp is held until the release flag
  a_r8_ovt_hold: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MD_OVT && !tempLoFlag && !batOffFlag) |=> modeQ == MD_OVT);

  // R7: any wake leaves sleep for standby
  a_r7_sleep_wake: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MD_SLEEP && anyWake && !batOffFlag) |=> modeQ == MD_STBY);

  // R6: reset request in normal lands in standby
  a_r6_norm_reset: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MD_NORM && sysRstReq && !batOffFlag) |=> modeQ == MD_STBY);

endmodule

// File: rtl/pms_datapath.sv
module pms_datapath
  import pms_pkg::*;
#(
  parameter int NUM_LIN   = 2,
  parameter int SHORT_CYC = 20,
  parameter int LONG_CYC  = 160
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  modeT                   modeQ,
  input  ctlStrobeT              strobe,
  input  logic                   longRstSel,
  input  logic [NUM_LIN:0]       stbCtrl,
  output logic                   v1En,
  output logic                   v2En,
  output logic [2*NUM_LIN+1:0]   xcvrState,
  output logic                   rstOut,
  output logic [NUM_MODES-1:0]   modeOneHot
);

  localparam int NXCVR = NUM_LIN + 1;
  localparam int CNT_W = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] rstCnt;
  logic             v2Sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (strobe.rstStart) begin
      rstCnt <= longRstSel ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC);
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              v2Sel <= 1'b0;
    else if (strobe.v2Load) v2Sel <= strobe.v2Val;
  end

  assign rstOut = (rstCnt != '0);
  assign v1En   = (modeQ == MD_STBY) || (modeQ == MD_NORM);
  assign v2En   = (modeQ == MD_NORM) && v2Sel;

  always_comb begin
    modeOneHot = '0;
    modeOneHot[int'(modeQ)] = 1'b1;
  end

  for (genvar i = 0; i < NXCVR; i++) begin : g_xcvr
    xcvrT code;
    always_comb begin
      case (modeQ)
        MD_STBY, MD_SLEEP: code = stbCtrl[i] ? XS_LOW : XS_OFF;
        MD_NORM:           code = stbCtrl[i] ? XS_LOW : XS_ACT;
        default:           code = XS_OFF;
      endcase
    end
    assign xcvrState[2*i +: 2] = code;
  end

  // R3: a start loads the selected pulse length
  a_r3_pulse_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstStart |=> rstOut && (rstCnt == ($past(longRstSel) ? CNT_W'(LONG_CYC) : CNT_W'(SHORT_CYC))));

  // R12: without a new cause the pulse counts down by one per cycle
  a_r12_pulse_count: assert property (@(posedge clk) disable iff (!rstN)
    (rstOut && !strobe.rstStart) |=> rstCnt == $past(rstCnt) - CNT_W'(1));

endmodule

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup
  import pms_pkg::*;
#(
  parameter int NUM_LIN   = 2,
  parameter int SHORT_CYC = 20,
  parameter int LONG_CYC  = 160
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   batOnFlag,
  input  logic                   batOffFlag,
  input  logic                   tempHiFlag,
  input  logic                   tempLoFlag,
  input  logic                   wakeCan,
  input  logic [NUM_LIN-1:0]     wakeLin,
  input  logic                   wakeLocal,
  input  logic                   sysRstReq,
  input  logic                   modeWrEn,
  input  logic [1:0]             modeWrData,
  input  logic                   longRstSel,
  input  logic [NUM_LIN:0]       stbCtrl,
  output logic                   v1En,
  output logic                   v2En,
  output logic [2*NUM_LIN+1:0]   xcvrState,
  output logic                   rstOut,
  output logic [4:0]             modeOneHot
);

  modeT      modeQ;
  ctlStrobeT strobe;

  pms_ctrl #(.NUM_LIN(NUM_LIN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .batOnFlag  (batOnFlag),
    .batOffFlag (batOffFlag),
    .tempHiFlag (tempHiFlag),
    .tempLoFlag (tempLoFlag),
    .wakeCan    (wakeCan),
    .wakeLin    (wakeLin),
    .wakeLocal  (wakeLocal),
    .sysRstReq  (sysRstReq),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .modeQ      (modeQ),
    .strobe     (strobe)
  );

  pms_datapath #(
    .NUM_LIN   (NUM_LIN),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .modeQ      (modeQ),
    .strobe     (strobe),
    .longRstSel (longRstSel),
    .stbCtrl    (stbCtrl),
    .v1En       (v1En),
    .v2En       (v2En),
    .xcvrState  (xcvrState),
    .rstOut     (rstOut),
    .modeOneHot (modeOneHot)
  );

endmodule

// File: tb/pwr_mode_sup_tb.sv
`timescale 1ns/1ps
module pwr_mode_sup_tb;

  localparam int NL = 2;
  localparam int SC = 4;
  localparam int LC = 12;
  localparam int NX = NL + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic batOnFlag = 0, batOffFlag = 0, tempHiFlag = 0, tempLoFlag = 0;
  logic wakeCan = 0, wakeLocal = 0, sysRstReq = 0, modeWrEn = 0, longRstSel = 0;
  logic [NL-1:0] wakeLin = '0;
  logic [1:0] modeWrData = 2'b00;
  logic [NL:0] stbCtrl = '0;
  logic v1En, v2En, rstOut;
  logic [2*NX-1:0] xcvrState;
  logic [4:0] modeOneHot;

  always #10 clk = ~clk;

  pwr_mode_sup #(.NUM_LIN(NL), .SHORT_CYC(SC), .LONG_CYC(LC)) u_dut (
    .clk(clk), .rstN(rstN), .batOnFlag(batOnFlag), .batOffFlag(batOffFlag),
    .tempHiFlag(tempHiFlag), .tempLoFlag(tempLoFlag), .wakeCan(wakeCan),
    .wakeLin(wakeLin), .wakeLocal(wakeLocal), .sysRstReq(sysRstReq),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .longRstSel(longRstSel),
    .stbCtrl(stbCtrl), .v1En(v1En), .v2En(v2En), .xcvrState(xcvrState),
    .rstOut(rstOut), .modeOneHot(modeOneHot)
  );

  typedef struct {
    string          tag;
    logic [4:0]     oh;
    logic           v1;
    logic           v2;
    logic           rst;
    logic [2*NX-1:0] xs;
  } expT;

  expT q[$];
  expT cur;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state: 0 Off, 1 Standby, 2 Normal, 3 Sleep, 4 Overtemp
  int mMode = 0;
  bit mV2 = 0;
  int mCnt = 0;

  function automatic expT predict(string tag);
    expT e;
    e.tag = tag;
    e.oh  = 5'(1 << mMode);
    e.v1  = (mMode == 1) || (mMode == 2);
    e.v2  = (mMode == 2) && mV2;
    e.rst = (mCnt != 0);
    for (int i = 0; i < NX; i++) begin
      if (mMode == 1 || mMode == 3)  e.xs[2*i +: 2] = stbCtrl[i] ? 2'b01 : 2'b00;
      else if (mMode == 2)           e.xs[2*i +: 2] = stbCtrl[i] ? 2'b01 : 2'b10;
      else                           e.xs[2*i +: 2] = 2'b00;
    end
    return e;
  endfunction

  task automatic step(string tag);
    bit start = 0;
    int nm = mMode;
    bit wk = wakeCan || (|wakeLin) || wakeLocal;
    if (batOffFlag) nm = 0;
    else case (mMode)
      0: if (batOnFlag) begin nm = 1; start = 1; end
      1: if (tempHiFlag) nm = 4;
         else if (sysRstReq) start = 1;
         else if (modeWrEn) begin
           if (modeWrData == 2'b01) nm = 3;
           else if (modeWrData[1]) begin nm = 2; mV2 = modeWrData[0]; end
         end
      2: if (sysRstReq) begin nm = 1; start = 1; end
         else if (modeWrEn) begin
           if (modeWrData == 2'b00) nm = 1;
           else if (modeWrData == 2'b01) nm = 3;
           else mV2 = modeWrData[0];
         end
      3: if (wk) nm = 1;
      4: if (tempLoFlag) nm = 1;
      default: nm = 0;
    endcase
    if (start) mCnt = longRstSel ? LC : SC;
    else if (mCnt > 0) mCnt--;
    mMode = nm;
    @(posedge clk);
    q.push_back(predict(tag));
    @(negedge clk);
    #1;
    wakeCan = 0; wakeLin = '0; wakeLocal = 0; sysRstReq = 0; modeWrEn = 0;
  endtask

  task automatic wr(logic [1:0] d);
    modeWrEn = 1; modeWrData = d;
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (modeOneHot !== cur.oh || v1En !== cur.v1 || v2En !== cur.v2 ||
          rstOut !== cur.rst || xcvrState !== cur.xs) begin
        errors++;
        $display("FAIL %s: got mode=%b v1=%b v2=%b rst=%b xs=%b, expected mode=%b v1=%b v2=%b rst=%b xs=%b",
                 cur.tag, modeOneHot, v1En, v2En, rstOut, xcvrState,
                 cur.oh, cur.v1, cur.v2, cur.rst, cur.xs);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); #1;
    // R1: reset state observed while reset is held
    q.push_back(predict("R1 reset"));
    @(negedge clk); #1;
    rstN = 1;
    step("R1 after release");

    // R8: write ignored while Off
    wr(2'b10); step("R8 write in Off");

    // R3: power-on, short pulse of SC cycles
    batOnFlag = 1; longRstSel = 0;
    step("R3 power-on");
    idle(SC + 1, "R3 short pulse");

    // R10: Standby codes
    stbCtrl = 3'b101; step("R10 standby codes");

    // R4: decode in Standby
    wr(2'b00); step("R4 write 00 in Standby");
    wr(2'b10); step("R4 write 10 to Normal");
    step("R10 normal codes");
    // R5: V2 control inside Normal
    wr(2'b11); step("R5 write 11 in Normal");
    wr(2'b10); step("R5 write 10 in Normal");
    wr(2'b11); step("R5 write 11 again");

    // R6: reset request beats a write in Normal
    sysRstReq = 1; wr(2'b01); step("R6 reset in Normal");
    idle(2, "R6 pulse running");
    // R12: restart with long length mid-pulse
    longRstSel = 1; sysRstReq = 1; step("R12 restart in Standby");
    idle(LC + 1, "R12 long pulse");

    // R4 / R7: Sleep entry, ignored inputs, wake
    wr(2'b01); step("R4 write 01 to Sleep");
    wr(2'b10); step("R7 write ignored in Sleep");
    sysRstReq = 1; step("R7 reset ignored in Sleep");
    wakeLin[1] = 1; step("R7 LIN wake");
    wr(2'b11); step("R4 write 11 to Normal");
    wr(2'b01); step("R5 write 01 to Sleep");
    wakeLocal = 1; step("R7 local wake");
    wr(2'b01); step("R4 Sleep again");
    wakeCan = 1; step("R7 CAN wake");
    wr(2'b10); step("R5 to Normal");
    wr(2'b00); step("R5 write 00 to Standby");

    // R8: overtemp beats reset and write
    tempHiFlag = 1; sysRstReq = 1; wr(2'b10); step("R8 overtemp entry");
    tempHiFlag = 0; wr(2'b11); step("R8 write in Overtemp");
    idle(2, "R8 hold Overtemp");
    tempLoFlag = 1; step("R8 release");
    tempLoFlag = 0;
    idle(1, "R9 standby enables");

    // R2: power-off beats everything
    stbCtrl = 3'b010;
    wr(2'b11); step("R9 normal V2 on");
    batOffFlag = 1; sysRstReq = 1; step("R2 power-off");
    step("R2 hold Off");
    batOffFlag = 0; step("R3 long power-on");
    idle(LC + 1, "R3 long pulse");
    step("R11 one-hot");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule